// File: doc/BRIEF.md
# PHY Management Register Model

This block models the management side of an Ethernet PHY as seen by a MAC. Software reaches the PHY through one 32-bit management frame register. Writing that register carries out a single PHY register access straight away. Bit 29 of the written word picks the direction, bits [27:18] name the PHY register and bits [15:0] carry write data. When the access is a read, the low half of the frame register is replaced with the value returned by the PHY. Every frame write then sets a management-done flag, and software clears that flag with a separate strobe.

Behind the frame register sit five PHY registers: control, status, advertisement, interrupt sources and interrupt mask. A link-up input is watched on every clock. Each evaluation of the link updates the link and autonegotiation bits of status and raises interrupt sources. The link is evaluated after reset, after a PHY soft reset and on every change of the input. Reading the source register clears it. The PHY interrupt output is high while any source is set whose mask bit is also set. No serial MDIO timing is modelled, and autonegotiation finishes in the same cycle it is requested.

Top module: `phyMgmtModel`

## Requirements
- R1: After reset, frameQ = 0, mgmtDone = 0 and phyIrq = 0. The PHY registers reset to control 0x3000, status 0x7809, advertisement 0x01E1, mask 0 and sources 0. The link input is then evaluated at the first clock edge.
- R2: A frame write with bit 29 clear writes bits [15:0] to the PHY register numbered by bits [27:18]. The frame register then holds the whole written word.
- R3: A frame write with bit 29 set reads the numbered register. The frame register holds the written bits [31:16] and the read value in [15:0]. Register numbers other than 0, 1, 4, 29 and 30 read as 0.
- R4: mgmtDone is high after the clock edge of any frame write, including ignored ones. A doneClr pulse without a frame write lowers it, and a frame write wins over a doneClr in the same cycle.
- R5: Each link evaluation works on status bit 2 (link) and bit 5 (autonegotiation complete). With the link up it sets both bits and raises source bit 7 (energy on) and source bit 6 (autonegotiation complete). With the link down it clears both bits and raises source bit 4 (link down). A link evaluation happens after reset, after a soft reset and at each change of linkUp.
- R6: Writing register 0 with bit 15 set is a soft reset. It restores the R1 values of all five PHY registers and then evaluates the link. Writing register 0 with bit 15 clear stores the data ANDed with 0x7980. If data bit 12 is also set, that write sets status bit 5 and raises source bit 6.
- R7: Reading register 29 returns the sources and clears them. A source raised by a link evaluation in the same cycle survives the clear.
- R8: Register 30 is the interrupt mask. Only data bits [7:0] are stored, and it reads back zero-extended.
- R9: A register number above 31 is ignored. A write to such a number changes no PHY register, and a read of it returns 0 and does not clear the sources.
- R10: phyIrq is high exactly when some source bit and the same mask bit are both set. It follows any change of either register in the same cycle.
- R11: Register 4 (advertisement) stores and returns all 16 data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameWe | input | 1 | Write strobe for the management frame register |
| frameWdata | input | 32 | Word written to the frame register |
| frameQ | output | 32 | Current frame register contents |
| doneClr | input | 1 | Clears the management-done flag |
| mgmtDone | output | 1 | Management-done interrupt flag |
| linkUp | input | 1 | Current link state from the line side |
| phyIrq | output | 1 | PHY interrupt, OR of sources masked by the mask |

## Verification
The embedded assertions watch several things on every cycle. They check that the done flag sets and clears, and that a link evaluation moves the status and source bits in the right direction. They also check that a read of register 29 empties the sources, that a read keeps the upper half of the frame word, and that control, advertisement and mask stay put unless a valid write reaches them. The directed scenarios cover the rest. They read back the reset and soft-reset values through the frame register and check the exact control write mask and the autonegotiation kick. They show that a high register number neither writes nor clears anything, and that the interrupt output tracks every combination of sources and mask.

// File: rtl/phyMgmtPkg.sv
package phyMgmtPkg;
  localparam int FRAME_W   = 32;
  localparam int DATA_W    = 16;
  localparam int REGNUM_W  = 10;
  localparam int IDX_W     = 5;
  localparam int SRC_W     = 8;
  localparam int MASK_W    = 8;
  localparam int RD_BIT    = 29;
  localparam int REG_LSB   = 18;

  localparam logic [IDX_W-1:0] REG_CTL = 5'd0;
  localparam logic [IDX_W-1:0] REG_STS = 5'd1;
  localparam logic [IDX_W-1:0] REG_ADV = 5'd4;
  localparam logic [IDX_W-1:0] REG_SRC = 5'd29;
  localparam logic [IDX_W-1:0] REG_MSK = 5'd30;

  localparam logic [DATA_W-1:0] CTL_RST  = 16'h3000;
  localparam logic [DATA_W-1:0] STS_RST  = 16'h7809;
  localparam logic [DATA_W-1:0] ADV_RST  = 16'h01E1;
  localparam logic [DATA_W-1:0] CTL_KEEP = 16'h7980;
  localparam logic [DATA_W-1:0] STS_LINK = 16'h0024;
  localparam logic [DATA_W-1:0] STS_ANEG = 16'h0020;
  localparam int CTL_RST_BIT  = 15;
  localparam int CTL_ANEG_BIT = 12;

  localparam logic [SRC_W-1:0] SRC_DOWN   = 8'h10;
  localparam logic [SRC_W-1:0] SRC_ANEG   = 8'h40;
  localparam logic [SRC_W-1:0] SRC_ENERGY = 8'h80;

  typedef struct packed {
    logic             rdOp;
    logic             wrOp;
    logic [IDX_W-1:0] regIdx;
    logic             softRst;
    logic             linkApply;
    logic             linkVal;
  } phyStrobe_t;
endpackage

// File: rtl/phyMgmtCtrl.sv
module phyMgmtCtrl
  import phyMgmtPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameWe,
  input  logic                cmdRd,
  input  logic [REGNUM_W-1:0] regNum,
  input  logic                ctlRstBit,
  input  logic                linkUp,
  output phyStrobe_t          str
);
  logic linkEval;
  logic linkSeen;
  logic regValid;

  assign regValid = (regNum[REGNUM_W-1:IDX_W] == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linkEval <= 1'b1;
      linkSeen <= 1'b0;
    end else begin
      linkEval <= 1'b0;
      linkSeen <= linkUp;
    end
  end

  always_comb begin
    str.rdOp      = frameWe & cmdRd & regValid;
    str.wrOp      = frameWe & ~cmdRd & regValid;
    str.regIdx    = regNum[IDX_W-1:0];
    str.softRst   = str.wrOp & (str.regIdx == REG_CTL) & ctlRstBit;
    str.linkApply = linkEval | (linkUp != linkSeen) | str.softRst;
    str.linkVal   = linkUp;
  end

  // R9
  badRegQuiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameWe && !regValid) |-> (!str.rdOp && !str.wrOp && !str.softRst));
endmodule

// File: rtl/phyMgmtData.sv
module phyMgmtData
  import phyMgmtPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  phyStrobe_t         str,
  input  logic               frameWe,
  input  logic [FRAME_W-1:0] frameWd,
  input  logic               doneClr,
  output logic [FRAME_W-1:0] frameQ,
  output logic               mgmtDone,
  output logic               phyIrq
);
  logic [DATA_W-1:0] ctlQ, stsQ, advQ;
  logic [SRC_W-1:0]  srcQ;
  logic [MASK_W-1:0] mskQ;
  logic [DATA_W-1:0] ctlN, stsN, advN;
  logic [SRC_W-1:0]  srcN;
  logic [MASK_W-1:0] mskN;
  logic [DATA_W-1:0] readVal;
  logic [DATA_W-1:0] wrData;

  assign wrData = frameWd[DATA_W-1:0];

  always_comb begin
    readVal = '0;
    if (str.rdOp) begin
      case (str.regIdx)
        REG_CTL: readVal = ctlQ;
        REG_STS: readVal = stsQ;
        REG_ADV: readVal = advQ;
        REG_SRC: readVal = {{(DATA_W-SRC_W){1'b0}}, srcQ};
        REG_MSK: readVal = {{(DATA_W-MASK_W){1'b0}}, mskQ};
        default: readVal = '0;
      endcase
    end
  end

  always_comb begin
    ctlN = ctlQ;
    stsN = stsQ;
    advN = advQ;
    srcN = srcQ;
    mskN = mskQ;
    if (str.rdOp && str.regIdx == REG_SRC) begin
      srcN = '0;
    end
    if (str.wrOp) begin
      case (str.regIdx)
        REG_CTL: begin
          if (str.softRst) begin
            ctlN = CTL_RST;
            stsN = STS_RST;
            advN = ADV_RST;
            srcN = '0;
            mskN = '0;
          end else begin
            ctlN = wrData & CTL_KEEP;
            if (wrData[CTL_ANEG_BIT]) begin
              stsN = stsN | STS_ANEG;
              srcN = srcN | SRC_ANEG;
            end
          end
        end
        REG_ADV: advN = wrData;
        REG_MSK: mskN = wrData[MASK_W-1:0];
        default: ;
      endcase
    end
    if (str.linkApply) begin
      if (str.linkVal) begin
        stsN = stsN | STS_LINK;
        srcN = srcN | SRC_ENERGY | SRC_ANEG;
      end else begin
        stsN = stsN & ~STS_LINK;
        srcN = srcN | SRC_DOWN;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ     <= CTL_RST;
      stsQ     <= STS_RST;
      advQ     <= ADV_RST;
      srcQ     <= '0;
      mskQ     <= '0;
      frameQ   <= '0;
      mgmtDone <= 1'b0;
    end else begin
      ctlQ <= ctlN;
      stsQ <= stsN;
      advQ <= advN;
      srcQ <= srcN;
      mskQ <= mskN;
      if (frameWe) begin
        frameQ <= frameWd[RD_BIT] ? {frameWd[FRAME_W-1:DATA_W], readVal} : frameWd;
      end
      if (frameWe) begin
        mgmtDone <= 1'b1;
      end else if (doneClr) begin
        mgmtDone <= 1'b0;
      end
    end
  end

  assign phyIrq = |(srcQ & mskQ);

  // R4
  doneSet_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameWe |=> mgmtDone);
  // R4
  doneClr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneClr && !frameWe) |=> !mgmtDone);
  // R3
  frameRdHi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameWe && frameWd[RD_BIT]) |=> (frameQ[FRAME_W-1:DATA_W] == $past(frameWd[FRAME_W-1:DATA_W])));
  // R7
  srcClr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (str.rdOp && str.regIdx == REG_SRC && !str.linkApply) |=> (srcQ == '0));
  // R5
  linkUpApply_chk: assert property (@(posedge clk) disable iff (!rstN)
    (str.linkApply && str.linkVal) |=> (stsQ[5] && stsQ[2] && srcQ[7] && srcQ[6]));
  // R5
  linkDnApply_chk: assert property (@(posedge clk) disable iff (!rstN)
    (str.linkApply && !str.linkVal) |=> (!stsQ[5] && !stsQ[2] && srcQ[4]));
  // R9
  keepRegs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !str.wrOp |=> ($stable(ctlQ) && $stable(advQ) && $stable(mskQ)));
  // R6
  ctlRsv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlQ & ~CTL_KEEP) == '0);
endmodule

// File: rtl/phyMgmtModel.sv
module phyMgmtModel
  import phyMgmtPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameWe,
  input  logic [FRAME_W-1:0] frameWdata,
  output logic [FRAME_W-1:0] frameQ,
  input  logic               doneClr,
  output logic               mgmtDone,
  input  logic               linkUp,
  output logic               phyIrq
);
  phyStrobe_t str;

  phyMgmtCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameWe   (frameWe),
    .cmdRd     (frameWdata[RD_BIT]),
    .regNum    (frameWdata[REG_LSB+REGNUM_W-1:REG_LSB]),
    .ctlRstBit (frameWdata[CTL_RST_BIT]),
    .linkUp    (linkUp),
    .str       (str)
  );

  phyMgmtData u_data (
    .clk      (clk),
    .rstN     (rstN),
    .str      (str),
    .frameWe  (frameWe),
    .frameWd  (frameWdata),
    .doneClr  (doneClr),
    .frameQ   (frameQ),
    .mgmtDone (mgmtDone),
    .phyIrq   (phyIrq)
  );
endmodule

// File: tb/sim_phyMgmtModel.sv
module sim_phyMgmtModel;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameWe = 1'b0;
  logic [31:0] frameWdata = '0;
  logic [31:0] frameQ;
  logic        doneClr = 1'b0;
  logic        mgmtDone;
  logic        linkUp = 1'b1;
  logic        phyIrq;

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phyMgmtModel u0 (
    .clk(clk), .rstN(rstN), .frameWe(frameWe), .frameWdata(frameWdata),
    .frameQ(frameQ), .doneClr(doneClr), .mgmtDone(mgmtDone),
    .linkUp(linkUp), .phyIrq(phyIrq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkFrame(input bit rd, input int reg_n, input logic [15:0] d);
    logic [31:0] f;
    f = '0;
    f[29] = rd;
    f[27:18] = reg_n[9:0];
    f[15:0] = d;
    return f;
  endfunction

  task automatic doFrame(input logic [31:0] f);
    @(negedge clk);
    frameWe = 1'b1;
    frameWdata = f;
    @(posedge clk);
    @(negedge clk);
    frameWe = 1'b0;
  endtask

  task automatic rdReg(input int reg_n, output logic [15:0] v);
    doFrame(mkFrame(1'b1, reg_n, 16'h0000));
    v = frameQ[15:0];
  endtask

  task automatic wrReg(input int reg_n, input logic [15:0] d);
    doFrame(mkFrame(1'b0, reg_n, d));
  endtask

  task automatic setLink(input bit up);
    @(negedge clk);
    linkUp = up;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tReset();
    logic [15:0] v;
    chk("R1 frameQ at reset", frameQ, 32'h0);
    chk("R1 mgmtDone at reset", {31'b0, mgmtDone}, 32'h0);
    chk("R1 phyIrq at reset", {31'b0, phyIrq}, 32'h0);
    rdReg(0, v);  chk("R1 control reset", {16'h0, v}, 32'h3000);
    rdReg(1, v);  chk("R1 R5 status reset with link up", {16'h0, v}, 32'h782D);
    rdReg(4, v);  chk("R1 advertise reset", {16'h0, v}, 32'h01E1);
    rdReg(30, v); chk("R1 mask reset", {16'h0, v}, 32'h0);
    rdReg(29, v); chk("R5 sources after first link evaluation", {16'h0, v}, 32'h00C0);
    rdReg(29, v); chk("R7 sources cleared by read", {16'h0, v}, 32'h0);
  endtask

  task automatic tFrameAndDone();
    logic [31:0] f;
    f = 32'hC012_5A5A;
    f[29] = 1'b1;
    f[27:18] = 10'd7;
    doFrame(f);
    chk("R3 unimplemented read keeps upper half", frameQ, {f[31:16], 16'h0000});
    chk("R4 done after frame write", {31'b0, mgmtDone}, 32'h1);
    @(negedge clk); doneClr = 1'b1;
    @(posedge clk); @(negedge clk); doneClr = 1'b0;
    chk("R4 done cleared", {31'b0, mgmtDone}, 32'h0);
    f = mkFrame(1'b0, 4, 16'h0061);
    f[31:30] = 2'b10;
    @(negedge clk); frameWe = 1'b1; frameWdata = f; doneClr = 1'b1;
    @(posedge clk); @(negedge clk); frameWe = 1'b0; doneClr = 1'b0;
    chk("R2 write keeps whole word", frameQ, f);
    chk("R4 write wins over clear", {31'b0, mgmtDone}, 32'h1);
  endtask

  task automatic tControlAdv();
    logic [15:0] v;
    rdReg(4, v); chk("R11 advertise written", {16'h0, v}, 32'h0061);
    wrReg(4, 16'hFFFF);
    rdReg(4, v); chk("R11 advertise all bits", {16'h0, v}, 32'hFFFF);
    wrReg(0, 16'h7FFF);
    rdReg(0, v); chk("R6 control write mask", {16'h0, v}, 32'h7980);
    rdReg(29, v); chk("R6 autoneg kick raises source", {16'h0, v}, 32'h0040);
    wrReg(0, 16'h0100);
    rdReg(0, v); chk("R6 control plain write", {16'h0, v}, 32'h0100);
    rdReg(29, v); chk("R6 no kick without bit 12", {16'h0, v}, 32'h0);
  endtask

  task automatic tMaskIrq();
    logic [15:0] v;
    wrReg(30, 16'hFF10);
    rdReg(30, v); chk("R8 mask low byte only", {16'h0, v}, 32'h0010);
    chk("R10 no irq before source", {31'b0, phyIrq}, 32'h0);
    setLink(1'b0);
    chk("R10 irq on link down", {31'b0, phyIrq}, 32'h1);
    rdReg(1, v); chk("R5 status link down", {16'h0, v}, 32'h7809);
    rdReg(29, v); chk("R5 R7 link-down source", {16'h0, v}, 32'h0010);
    chk("R10 irq drops after clear", {31'b0, phyIrq}, 32'h0);
    setLink(1'b1);
    chk("R10 unmasked sources give no irq", {31'b0, phyIrq}, 32'h0);
    wrReg(30, 16'h0080);
    chk("R10 irq when mask meets source", {31'b0, phyIrq}, 32'h1);
  endtask

  task automatic tHighReg();
    logic [15:0] v;
    wrReg(62, 16'h00FF);
    rdReg(30, v); chk("R9 high write leaves mask", {16'h0, v}, 32'h0080);
    wrReg(32, 16'h8000);
    rdReg(0, v); chk("R9 high write no soft reset", {16'h0, v}, 32'h0100);
    chk("R4 done after ignored write", {31'b0, mgmtDone}, 32'h1);
    rdReg(61, v); chk("R9 high read returns zero", {16'h0, v}, 32'h0);
    rdReg(29, v); chk("R9 high read did not clear", {16'h0, v}, 32'h00C0);
  endtask

  task automatic tSoftReset();
    logic [15:0] v;
    wrReg(30, 16'h0040);
    setLink(1'b0);
    wrReg(0, 16'h8000);
    rdReg(0, v);  chk("R6 soft reset control", {16'h0, v}, 32'h3000);
    rdReg(4, v);  chk("R6 soft reset advertise", {16'h0, v}, 32'h01E1);
    rdReg(30, v); chk("R6 soft reset mask", {16'h0, v}, 32'h0);
    rdReg(1, v);  chk("R6 R5 soft reset status link down", {16'h0, v}, 32'h7809);
    rdReg(29, v); chk("R6 R5 soft reset link reevaluated", {16'h0, v}, 32'h0010);
    @(negedge clk);
    linkUp = 1'b1;
    frameWe = 1'b1;
    frameWdata = mkFrame(1'b1, 29, 16'h0);
    @(posedge clk); @(negedge clk); frameWe = 1'b0;
    chk("R7 read returns pre-edge sources", {16'h0, frameQ[15:0]}, 32'h0);
    rdReg(29, v); chk("R7 same-cycle link source survives", {16'h0, v}, 32'h00C0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tFrameAndDone();
    tControlAdv();
    tMaskIrq();
    tHighReg();
    tSoftReset();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule